// File: doc/BRIEF.md
# Configuration Access Address Decoder

This block sits between a configuration requester and a flat memory window that carries configuration space. Each request names a bus number, a device/function number and a register offset; the block packs them into one window address and decides whether the access may go ahead. Accesses on the root bus are allowed only for device/function zero. Accesses to any other bus are allowed only while the link is up. Nothing is allowed while the window is off or the window hardware is absent. A refused read hands back all-ones data. A refused write never reaches the window.

The block holds the window control word (enable and size) in a local register. The size value is reported as the last bus number behind the port. On request, the block also emits one write of the root port's bus-number word, which is built from the root bus, the bus after it, and the last bus.

Four states run the block. `ST_IDLE` waits for work. A request moves it to `ST_DECODE`; otherwise a header-load request moves it to `ST_HDR`. `ST_DECODE` always moves to `ST_RESP`, where the result is presented for one cycle. `ST_RESP` and `ST_HDR` both return to `ST_IDLE`.

Top module: `cfg_access_decoder`

## Requirements
- R1: The window address is the request's bus number shifted left by 20, ORed with the 8-bit device/function shifted left by 12, ORed with the 12-bit register offset (28 bits in all).
- R2: A request whose bus equals the root bus and whose device/function is not zero is refused (`resp_ok` low).
- R3: A request to any bus other than the root bus is refused unless bit 0 of `link_word` is 1. A root-bus request with device/function zero does not depend on the link.
- R4: Every request is refused while the control enable bit (bit 0 of the written control word) is 0, or while bit 0 of `cap_word` (window present) is 0.
- R5: `last_bus` equals control bits 20:16 of the last control write, zero-extended to 8 bits. After reset it is 12, and it changes only on a control write.
- R6: A refused read returns `resp_rdata` = all ones. A refused write leaves `win_wr` low. An accepted write pulses `win_wr` with `resp_done`. An accepted read returns zero on `resp_rdata`.
- R7: A request accepted at a clock edge (`req_valid` while `req_ready`) is answered by `resp_done` high for exactly one cycle, one cycle after the accepting edge's following edge (state path `ST_IDLE`→`ST_DECODE`→`ST_RESP`). `req_ready` is low while busy.
- R8: A header-load request (`hdr_go` in `ST_IDLE`) pulses `hdr_we` for one cycle. During that pulse, `hdr_data` holds the root bus in bits 7:0, root+1 in bits 15:8, the last bus in bits 23:16, and zero in bits 31:24.
- R9: If `req_valid` and `hdr_go` arrive together in `ST_IDLE`, the configuration request is served and no header write is issued for that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Load the window control register |
| ctrl_wdata | input | 32 | Control word: bit 0 enable, bits 20:16 size |
| cap_word | input | 32 | Capability word: bit 0 window present |
| link_word | input | 32 | Link status: bit 0 link up |
| root_bus | input | 8 | Root bus number |
| req_valid | input | 1 | Configuration request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_write | input | 1 | 1 for write, 0 for read |
| req_bus | input | 8 | Target bus number |
| req_devfn | input | 8 | Target device/function |
| req_offset | input | 12 | Register offset |
| req_wdata | input | 32 | Write data |
| hdr_go | input | 1 | Request a bus-number header write |
| resp_done | output | 1 | One-cycle result strobe |
| resp_ok | output | 1 | Access allowed (valid with resp_done) |
| resp_write | output | 1 | Direction of the answered request |
| resp_addr | output | 28 | Computed window address |
| resp_rdata | output | 32 | All ones for a refused read, else zero |
| win_wr | output | 1 | Write strobe to the window |
| win_wdata | output | 32 | Write data to the window |
| last_bus | output | 8 | Last bus number from the size field |
| hdr_we | output | 1 | Header write strobe |
| hdr_data | output | 32 | Packed bus-number word |

## Verification
Suppose the state register skips `ST_DECODE` or stays in `ST_RESP`. Then `resp_done` appears a cycle early or lasts two cycles, and the scoreboard sees this on the very next response. A wrongly latched request field or a misplaced shift shows up in `resp_addr` in that same response cycle. A bad filter decision flips `resp_ok`, `resp_rdata` or `win_wr` at once. A stale control register shows up in `last_bus` one cycle after the control write, and in the packed header word on the next header pulse.

// File: rtl/cfgdec_pkg.sv
package cfgdec_pkg;
    localparam int BUS_W   = 8;
    localparam int DEVFN_W = 8;
    localparam int OFS_W   = 12;
    localparam int ADDR_W  = BUS_W + DEVFN_W + OFS_W;
    localparam int DATA_W  = 32;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DECODE,
        ST_RESP,
        ST_HDR
    } cfgdec_state_e;

    typedef struct packed {
        logic               write;
        logic [BUS_W-1:0]   bus;
        logic [DEVFN_W-1:0] devfn;
        logic [OFS_W-1:0]   offset;
        logic [DATA_W-1:0]  wdata;
    } cfg_req_t;
endpackage

// File: rtl/cfgdec_addr.sv
module cfgdec_addr
    import cfgdec_pkg::*;
(
    input  cfg_req_t          req,
    output logic [ADDR_W-1:0] addr
);
    localparam int DEV_SHIFT = OFS_W;
    localparam int BUS_SHIFT = DEVFN_W + OFS_W;

    always_comb begin
        addr = (ADDR_W'(req.bus)   << BUS_SHIFT)
             | (ADDR_W'(req.devfn) << DEV_SHIFT)
             |  ADDR_W'(req.offset);
    end
endmodule

// File: rtl/cfgdec_filter.sv
module cfgdec_filter
    import cfgdec_pkg::*;
(
    input  logic               win_en,
    input  logic               link_up,
    input  logic [BUS_W-1:0]   root_bus,
    input  logic [BUS_W-1:0]   bus,
    input  logic [DEVFN_W-1:0] devfn,
    output logic               allow
);
    logic on_root;

    always_comb begin
        on_root = (bus == root_bus);
        if (!win_en)
            allow = 1'b0;
        else if (on_root)
            allow = (devfn == '0);
        else
            allow = link_up;
    end
endmodule

// File: rtl/cfgdec_busword.sv
module cfgdec_busword
    import cfgdec_pkg::*;
(
    input  logic [BUS_W-1:0]  root_bus,
    input  logic [BUS_W-1:0]  last_bus,
    output logic [DATA_W-1:0] word
);
    localparam int PAD_W = DATA_W - 3 * BUS_W;

    always_comb begin
        word = {{PAD_W{1'b0}}, last_bus, root_bus + BUS_W'(1), root_bus};
    end
endmodule

// File: rtl/cfg_access_decoder.sv
module cfg_access_decoder
    import cfgdec_pkg::*;
#(
    parameter int SIZE_LSB = 16,
    parameter int SIZE_W   = 5,
    parameter int DEF_SIZE = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctrl_we,
    input  logic [DATA_W-1:0]  ctrl_wdata,
    input  logic [DATA_W-1:0]  cap_word,
    input  logic [DATA_W-1:0]  link_word,
    input  logic [BUS_W-1:0]   root_bus,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [BUS_W-1:0]   req_bus,
    input  logic [DEVFN_W-1:0] req_devfn,
    input  logic [OFS_W-1:0]   req_offset,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic               hdr_go,
    output logic               resp_done,
    output logic               resp_ok,
    output logic               resp_write,
    output logic [ADDR_W-1:0]  resp_addr,
    output logic [DATA_W-1:0]  resp_rdata,
    output logic               win_wr,
    output logic [DATA_W-1:0]  win_wdata,
    output logic [BUS_W-1:0]   last_bus,
    output logic               hdr_we,
    output logic [DATA_W-1:0]  hdr_data
);
    localparam int SIZE_MSB = SIZE_LSB + SIZE_W - 1;

    cfgdec_state_e state_q, state_d;
    cfg_req_t      req_q;
    logic [BUS_W-1:0]  root_q;
    logic              ctrl_en_q;
    logic [SIZE_W-1:0] size_q;
    logic              ok_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] addr_w;
    logic              allow_w;
    logic              win_en;

    logic unused_bits;
    assign unused_bits = ^{ctrl_wdata[DATA_W-1:SIZE_MSB+1], ctrl_wdata[SIZE_LSB-1:1],
                           cap_word[DATA_W-1:1], link_word[DATA_W-1:1]};

    // window control register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_en_q <= 1'b0;
            size_q    <= SIZE_W'(DEF_SIZE);
        end else if (ctrl_we) begin
            ctrl_en_q <= ctrl_wdata[0];
            size_q    <= ctrl_wdata[SIZE_MSB:SIZE_LSB];
        end
    end

    assign win_en   = ctrl_en_q & cap_word[0];
    assign last_bus = BUS_W'(size_q);

    cfgdec_addr u_addr (
        .req  (req_q),
        .addr (addr_w)
    );

    cfgdec_filter u_filter (
        .win_en   (win_en),
        .link_up  (link_word[0]),
        .root_bus (root_q),
        .bus      (req_q.bus),
        .devfn    (req_q.devfn),
        .allow    (allow_w)
    );

    cfgdec_busword u_busword (
        .root_bus (root_q),
        .last_bus (last_bus),
        .word     (hdr_data)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid)
                    state_d = ST_DECODE;
                else if (hdr_go)
                    state_d = ST_HDR;
            end
            ST_DECODE: state_d = ST_RESP;
            ST_RESP:   state_d = ST_IDLE;
            ST_HDR:    state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // datapath capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= '0;
            root_q <= '0;
            ok_q   <= 1'b0;
            addr_q <= '0;
        end else begin
            if (state_q == ST_IDLE && (req_valid || hdr_go)) begin
                root_q <= root_bus;
                if (req_valid) begin
                    req_q.write  <= req_write;
                    req_q.bus    <= req_bus;
                    req_q.devfn  <= req_devfn;
                    req_q.offset <= req_offset;
                    req_q.wdata  <= req_wdata;
                end
            end
            if (state_q == ST_DECODE) begin
                ok_q   <= allow_w;
                addr_q <= addr_w;
            end
        end
    end

    // outputs
    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        resp_done  = (state_q == ST_RESP);
        hdr_we     = (state_q == ST_HDR);
        resp_ok    = resp_done & ok_q;
        resp_write = req_q.write;
        resp_addr  = addr_q;
        win_wdata  = req_q.wdata;
        win_wr     = resp_done & ok_q & req_q.write;
        resp_rdata = (resp_done && !ok_q && !req_q.write) ? '1 : '0;
    end

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        resp_done |=> !resp_done);

    a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid) |=> !req_ready);

    a_r8_hdr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_we |=> !hdr_we);

    a_r9_request_first: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid && hdr_go) |=> !hdr_we);

    a_r2_root_devfn: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_done && req_q.bus == root_q && req_q.devfn != '0) |-> !resp_ok);

    a_r6_refused_write: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_done && !resp_ok) |-> !win_wr);

    a_r5_size_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_we |=> $stable(last_bus));
endmodule

// File: tb/sim_cfg_access_decoder.sv
module sim_cfg_access_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_we = 1'b0;
    logic [31:0] ctrl_wdata = '0;
    logic [31:0] cap_word = '0;
    logic [31:0] link_word = '0;
    logic [7:0]  root_bus = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [7:0]  req_bus = '0;
    logic [7:0]  req_devfn = '0;
    logic [11:0] req_offset = '0;
    logic [31:0] req_wdata = '0;
    logic        hdr_go = 1'b0;
    logic        resp_done, resp_ok, resp_write, win_wr, hdr_we;
    logic [27:0] resp_addr;
    logic [31:0] resp_rdata, win_wdata, hdr_data;
    logic [7:0]  last_bus;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    typedef struct {
        bit        ok;
        bit        wr;
        bit [27:0] addr;
        bit [31:0] wd;
        int        acc;
        string     tag;
    } exp_t;
    exp_t sb[$];

    bit m_en = 0, m_cap = 0, m_link = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc++;

    cfg_access_decoder u0 (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .cap_word(cap_word), .link_word(link_word), .root_bus(root_bus),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_bus(req_bus), .req_devfn(req_devfn), .req_offset(req_offset),
        .req_wdata(req_wdata), .hdr_go(hdr_go), .resp_done(resp_done),
        .resp_ok(resp_ok), .resp_write(resp_write), .resp_addr(resp_addr),
        .resp_rdata(resp_rdata), .win_wr(win_wr), .win_wdata(win_wdata),
        .last_bus(last_bus), .hdr_we(hdr_we), .hdr_data(hdr_data)
    );

    task automatic chk(input bit cond, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic bit want_ok(input [7:0] b, input [7:0] d);
        if (!(m_en && m_cap)) return 0;
        if (b == root_bus) return d == 8'h00;
        return m_link;
    endfunction

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && resp_done) begin
            if (sb.size() == 0) begin
                chk(0, "R7 unexpected response", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(resp_ok == e.ok, e.tag, resp_ok, e.ok);
                chk(resp_addr == e.addr, "R1 address", resp_addr, e.addr);
                chk(resp_rdata == ((!e.ok && !e.wr) ? 32'hFFFF_FFFF : 32'h0), "R6 read data",
                    resp_rdata, (!e.ok && !e.wr) ? 32'hFFFF_FFFF : 32'h0);
                chk(win_wr == (e.ok && e.wr), "R6 window write", win_wr, e.ok && e.wr);
                if (e.ok && e.wr) chk(win_wdata == e.wd, "R6 write data", win_wdata, e.wd);
                chk(cyc == e.acc + 1, "R7 response timing", cyc, e.acc + 1);
            end
        end
    end

    task automatic set_ctrl(input bit en, input [4:0] size);
        @(negedge clk);
        ctrl_wdata = {11'h0, size, 15'h0, en};
        ctrl_we = 1'b1;
        @(posedge clk); #1;
        ctrl_we = 1'b0;
        m_en = en;
    endtask

    task automatic do_req(input bit wr, input [7:0] b, input [7:0] d, input [11:0] o,
                          input [31:0] wd, input string tag, input bit with_hdr);
        exp_t e;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_bus = b; req_devfn = d;
        req_offset = o; req_wdata = wd; hdr_go = with_hdr;
        e.ok = want_ok(b, d); e.wr = wr; e.addr = {b, d, o}; e.wd = wd; e.tag = tag;
        @(posedge clk); #1;
        req_valid = 1'b0; hdr_go = 1'b0;
        e.acc = cyc;
        sb.push_back(e);
        if (with_hdr) begin
            @(negedge clk);
            chk(hdr_we == 1'b0, "R9 header suppressed", hdr_we, 0);
        end
    endtask

    task automatic do_hdr(input [31:0] expw);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        hdr_go = 1'b1;
        @(posedge clk); #1;
        hdr_go = 1'b0;
        @(negedge clk);
        chk(hdr_we == 1'b1, "R8 header strobe", hdr_we, 1);
        chk(hdr_data == expw, "R8 header word", hdr_data, expw);
        @(negedge clk);
        chk(hdr_we == 1'b0, "R8 header one cycle", hdr_we, 0);
    endtask

    task automatic drain();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R7: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk(req_ready == 1'b1, "R7 ready after reset", req_ready, 1);
        chk(resp_done == 1'b0, "R7 no response after reset", resp_done, 0);
        chk(hdr_we == 1'b0, "R8 no header after reset", hdr_we, 0);
        chk(last_bus == 8'd12, "R5 default last bus", last_bus, 12);

        // R4: window off at reset
        cap_word = 32'h1; m_cap = 1; link_word = 32'h1; m_link = 1; root_bus = 8'h00;
        do_req(0, 8'h00, 8'h00, 12'h010, 0, "R4 disabled", 0);
        drain();

        set_ctrl(1, 5'd20);
        @(negedge clk);
        chk(last_bus == 8'd20, "R5 size field", last_bus, 20);

        do_req(0, 8'h00, 8'h00, 12'h010, 0, "R2 root fn0", 0);
        do_req(0, 8'h00, 8'h08, 12'h000, 0, "R2 root nonzero", 0);
        do_req(1, 8'h00, 8'h01, 12'h004, 32'hDEAD_BEEF, "R2 root nonzero write", 0);
        do_req(1, 8'h01, 8'h0A, 12'h3FC, 32'h1234_5678, "R3 link up write", 0);
        do_req(0, 8'hFF, 8'hFF, 12'hFFF, 0, "R1 max fields", 0);
        drain();

        link_word = 32'hFFFF_FFFE; m_link = 0;
        do_req(0, 8'h03, 8'h00, 12'h100, 0, "R3 link down", 0);
        do_req(1, 8'h03, 8'h00, 12'h100, 32'h5, "R3 link down write", 0);
        do_req(0, 8'h00, 8'h00, 12'h020, 0, "R3 root ignores link", 0);
        drain();
        link_word = 32'h1; m_link = 1;

        cap_word = 32'hFFFF_FFFE; m_cap = 0;
        do_req(0, 8'h02, 8'h00, 12'h000, 0, "R4 not present", 0);
        drain();
        cap_word = 32'h1; m_cap = 1;
        set_ctrl(0, 5'd20);
        do_req(1, 8'h00, 8'h00, 12'h000, 32'h9, "R4 window off write", 0);
        drain();
        set_ctrl(1, 5'd20);

        root_bus = 8'h10;
        do_hdr({8'h00, 8'd20, 8'h11, 8'h10});
        do_req(0, 8'h10, 8'h00, 12'h044, 0, "R2 moved root fn0", 0);
        do_req(0, 8'h10, 8'h10, 12'h044, 0, "R2 moved root nonzero", 0);
        do_req(0, 8'h00, 8'h10, 12'h044, 0, "R3 old root now downstream", 0);
        drain();

        set_ctrl(1, 5'd31);
        @(negedge clk);
        chk(last_bus == 8'd31, "R5 size max", last_bus, 31);
        do_hdr({8'h00, 8'd31, 8'h11, 8'h10});

        do_req(0, 8'h10, 8'h00, 12'h008, 0, "R9 request wins", 1);
        drain();
        chk(hdr_we == 1'b0, "R9 no late header", hdr_we, 0);
        chk(sb.size() == 0, "R7 all responses seen", sb.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule